// File: doc/BRIEF.md
# SDRAM Clock-Enable Power Sequencer

This block sits on the controller side of an SDRAM interface and alone drives the clock-enable pin. The main memory controller asks it to enter one of four low-power conditions: clock suspend, precharge power-down, self refresh or deep power-down. Later it asks the block to wake. The block also receives a flag that says whether every bank is precharged. It lowers and raises clock-enable at the right moments. It forces the command bus to a no-operation whenever the device must not see a real command. It raises a ready flag once normal commands may resume.

The block keeps a registered copy of the pin, so the value from the previous cycle and the value in the current cycle are both available. Each transition is decided from that pair. Leaving power-down, self refresh or suspend costs one cycle of forced no-operation after clock-enable rises. Leaving deep power-down holds the forced no-operation for a wait of about 200 microseconds. That wait is a cycle count derived from the clock frequency. The block does not queue requests: a request made while the block is away from normal operation is refused with a busy flag, and a request that needs idle banks while a bank is open is held off.

Top module: `sdram_cke_seq`

## Requirements
- R1: After reset the state code is 0 (normal), clock-enable is high, ready is high and forced no-operation is low.
- R2: A suspend request (kind 0) in normal state is accepted whatever the bank flag says. From the next cycle clock-enable is low and the state code is 1.
- R3: A wake in any low-power state raises clock-enable on the next cycle, with the state code at 5 (exit wait) and ready low. For suspend, power-down and self refresh, ready returns one cycle after that.
- R4: Whenever clock-enable is low, forced no-operation is high and ready is low. The only way out of a low-power state is wake.
- R5: Power-down (kind 1), self refresh (kind 2) and deep power-down (kind 3) are accepted only while the bank flag reports all banks idle. Otherwise the held flag is high in that cycle and the state does not change. On acceptance the state code becomes kind+1.
- R6: In the first cycle with clock-enable high after a low period, forced no-operation is high.
- R7: After a deep power-down wake, clock-enable stays high with forced no-operation for exactly DPD_CYC cycles, where DPD_CYC = CLK_MHZ × DPD_WAIT_US. Ready rises after those cycles.
- R8: A request made while the state is not normal raises busy in that cycle and changes nothing. Wake in normal state is ignored.
- R9: The state code reads 0 normal, 1 suspend, 2 power-down, 3 self refresh, 4 deep power-down, 5 exit wait.
- R10: The accepted flag is high exactly in the cycle in which a request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Low-power entry request |
| req_kind | input | 2 | 0 suspend, 1 power-down, 2 self refresh, 3 deep power-down |
| wake | input | 1 | Request to leave the current low-power state |
| banks_idle | input | 1 | All banks precharged |
| cke | output | 1 | SDRAM clock-enable pin |
| force_nop | output | 1 | Command bus must carry NOP or deselect |
| ready | output | 1 | Normal commands may be issued |
| accepted | output | 1 | Request taken this cycle |
| busy | output | 1 | Request refused, transition in progress |
| held | output | 1 | Request refused, a bank is open |
| state_dbg | output | 3 | State code |

## Verification
The hardest situation to reach is the end of the long deep power-down exit window while other inputs are active. In that case the bench must show that ready rises exactly on time and that a request made during the window gets busy and does not shorten it. The bench shrinks the wait through parameters to a few hundred cycles. It then drives requests and wakes inside the window, and it counts the forced no-operation cycles from the rising clock-enable. A behavioural model, updated on each edge, predicts every output so that mismatches at any cycle are caught.

// File: rtl/sdram_cke_pkg.sv
package sdram_cke_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL  = 3'd0,
    ST_SUSPEND = 3'd1,
    ST_PWRDN   = 3'd2,
    ST_SELFREF = 3'd3,
    ST_DPD     = 3'd4,
    ST_EXIT    = 3'd5
  } cke_state_e;

  typedef enum logic [1:0] {
    K_SUSPEND = 2'd0,
    K_PWRDN   = 2'd1,
    K_SELFREF = 2'd2,
    K_DPD     = 2'd3
  } req_kind_e;

  // cycles in the deep power-down exit window
  function automatic int unsigned dpd_cycles(input int unsigned mhz, input int unsigned us);
    return mhz * us;
  endfunction

  // low-power state reached from a request kind
  function automatic cke_state_e target_of(input logic [1:0] kind);
    return cke_state_e'({1'b0, kind} + 3'd1);
  endfunction

  // only suspend may be entered with open banks
  function automatic logic needs_idle(input logic [1:0] kind);
    return kind != K_SUSPEND;
  endfunction

endpackage

// File: rtl/cke_req_gate.sv
module cke_req_gate (
  input  logic       req_valid,
  input  logic [1:0] req_kind,
  input  logic       banks_idle,
  input  logic       in_normal,
  output logic       accept,
  output logic       held,
  output logic       busy
);
  import sdram_cke_pkg::*;

  logic gate_ok;

  always_comb begin
    gate_ok = !needs_idle(req_kind) || banks_idle;
    accept  = req_valid && in_normal && gate_ok;
    held    = req_valid && in_normal && !gate_ok;
    busy    = req_valid && !in_normal;
  end
endmodule

// File: rtl/cke_exit_timer.sv
module cke_exit_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (load)     cnt <= load_val;
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = run && (cnt == '0);
endmodule

// File: rtl/cke_pin_track.sv
module cke_pin_track (
  input  logic clk,
  input  logic rst_n,
  input  logic cke_now,
  output logic cke_prev,
  output logic rise_ev,
  output logic fall_ev
);
  always_ff @(posedge clk) begin
    if (!rst_n) cke_prev <= 1'b1;
    else        cke_prev <= cke_now;
  end

  assign rise_ev = !cke_prev && cke_now;
  assign fall_ev = cke_prev && !cke_now;
endmodule

// File: rtl/sdram_cke_seq.sv
module sdram_cke_seq #(
  parameter int unsigned CLK_MHZ     = 250,
  parameter int unsigned DPD_WAIT_US = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_kind,
  input  logic       wake,
  input  logic       banks_idle,
  output logic       cke,
  output logic       force_nop,
  output logic       ready,
  output logic       accepted,
  output logic       busy,
  output logic       held,
  output logic [2:0] state_dbg
);
  import sdram_cke_pkg::*;

  localparam int unsigned DPD_CYC = dpd_cycles(CLK_MHZ, DPD_WAIT_US);
  localparam int unsigned CNT_W   = $clog2(DPD_CYC + 1);

  cke_state_e       state, state_nx;
  logic             in_normal, in_low;
  logic             timer_load, timer_done;
  logic [CNT_W-1:0] timer_val;
  logic             cke_prev, cke_rise_ev, cke_fall_ev;

  assign in_normal = (state == ST_NORMAL);
  assign in_low    = (state == ST_SUSPEND) || (state == ST_PWRDN) ||
                     (state == ST_SELFREF) || (state == ST_DPD);

  cke_req_gate u_gate (
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .banks_idle(banks_idle),
    .in_normal (in_normal),
    .accept    (accepted),
    .held      (held),
    .busy      (busy)
  );

  assign timer_load = in_low && wake;
  assign timer_val  = (state == ST_DPD) ? CNT_W'(DPD_CYC - 1) : '0;

  cke_exit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (timer_load),
    .load_val(timer_val),
    .run     (state == ST_EXIT),
    .done    (timer_done)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_NORMAL:  if (accepted) state_nx = target_of(req_kind);
      ST_SUSPEND,
      ST_PWRDN,
      ST_SELFREF,
      ST_DPD:     if (wake) state_nx = ST_EXIT;
      ST_EXIT:    if (timer_done) state_nx = ST_NORMAL;
      default:    state_nx = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_NORMAL;
    else        state <= state_nx;
  end

  assign cke       = !in_low;
  assign force_nop = !in_normal;
  assign ready     = in_normal;
  assign state_dbg = state;

  cke_pin_track u_pin (
    .clk     (clk),
    .rst_n   (rst_n),
    .cke_now (cke),
    .cke_prev(cke_prev),
    .rise_ev (cke_rise_ev),
    .fall_ev (cke_fall_ev)
  );
endmodule

// File: rtl/sdram_cke_seq_chk.sv
module sdram_cke_seq_chk #(
  parameter int unsigned DPD_CYC = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_kind,
  input logic       wake,
  input logic       banks_idle,
  input logic       cke,
  input logic       cke_prev,
  input logic       cke_rise_ev,
  input logic       cke_fall_ev,
  input logic       force_nop,
  input logic       ready,
  input logic       accepted,
  input logic       busy,
  input logic       held,
  input logic [2:0] state_dbg
);
  int unsigned exit_run;
  logic        from_dpd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exit_run <= 0;
      from_dpd <= 1'b0;
    end else begin
      exit_run <= (cke && force_nop) ? exit_run + 1 : 0;
      if (state_dbg == 3'd4) from_dpd <= 1'b1;
      else if (ready)        from_dpd <= 1'b0;
    end
  end

  a_r2_suspend_drops_cke: assert property (@(posedge clk) disable iff (!rst_n)
    accepted && req_kind == 2'd0 |=> !cke && state_dbg == 3'd1);

  a_r4_low_forces_nop: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> force_nop && !ready);

  a_r5_idle_gate: assert property (@(posedge clk) disable iff (!rst_n)
    accepted && req_kind != 2'd0 |-> banks_idle);

  a_r6_nop_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    cke_rise_ev |-> force_nop && !ready);

  a_r2_fall_from_normal: assert property (@(posedge clk) disable iff (!rst_n)
    cke_fall_ev |-> $past(accepted));

  a_r7_dpd_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) && from_dpd |-> exit_run == DPD_CYC);

  a_r8_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accepted && !held && !ready);

  a_r10_ready_pin_pair: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> cke && cke_prev);

  a_r8_wake_in_normal: assert property (@(posedge clk) disable iff (!rst_n)
    ready && wake && !req_valid |=> ready);
endmodule

bind sdram_cke_seq sdram_cke_seq_chk #(.DPD_CYC(DPD_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_kind   (req_kind),
  .wake       (wake),
  .banks_idle (banks_idle),
  .cke        (cke),
  .cke_prev   (cke_prev),
  .cke_rise_ev(cke_rise_ev),
  .cke_fall_ev(cke_fall_ev),
  .force_nop  (force_nop),
  .ready      (ready),
  .accepted   (accepted),
  .busy       (busy),
  .held       (held),
  .state_dbg  (state_dbg)
);

// File: tb/sdram_cke_seq_test.sv
module sdram_cke_seq_test;
  localparam int MHZ  = 250;
  localparam int US   = 1;
  localparam int WAIT = 250;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic       wake = 1'b0;
  logic       banks_idle = 1'b1;
  logic       cke, force_nop, ready, accepted, busy, held;
  logic [2:0] state_dbg;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int m_state = 0;
  int m_wait = 0;

  sdram_cke_seq #(.CLK_MHZ(MHZ), .DPD_WAIT_US(US)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .wake(wake), .banks_idle(banks_idle), .cke(cke), .force_nop(force_nop),
    .ready(ready), .accepted(accepted), .busy(busy), .held(held),
    .state_dbg(state_dbg)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // reference model: advances on each edge from the inputs in force then
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_state = 0;
      m_wait = 0;
    end else begin
      case (m_state)
        0: if (req_valid && (req_kind == 0 || banks_idle)) m_state = req_kind + 1;
        1, 2, 3, 4: if (wake) begin
          m_wait = (m_state == 4) ? WAIT : 1;
          m_state = 5;
        end
        5: begin
          m_wait--;
          if (m_wait == 0) m_state = 0;
        end
        default: m_state = 0;
      endcase
    end
  end

  // compare every output against the model on every falling edge
  always @(negedge clk) if (rst_n) begin
    int low;
    low = (m_state >= 1 && m_state <= 4);
    check("R2 cke", cke, !low);
    check("R4 force_nop", force_nop, m_state != 0);
    check("R3 ready", ready, m_state == 0);
    check("R9 state_dbg", state_dbg, m_state);
    check("R8 busy", busy, req_valid && m_state != 0);
    check("R5 held", held, req_valid && m_state == 0 && req_kind != 0 && !banks_idle);
    check("R10 accepted", accepted,
          req_valid && m_state == 0 && (req_kind == 0 || banks_idle));
  end

  task automatic drive(input logic v, input logic [1:0] k, input logic w, input logic bi);
    @(posedge clk);
    #1;
    req_valid = v; req_kind = k; wake = w; banks_idle = bi;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 2'd0, 1'b0, banks_idle);
  endtask

  initial begin
    int nops;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", state_dbg, 0);
    check("R1 reset cke", cke, 1);
    check("R1 reset ready", ready, 1);
    check("R1 reset nop", force_nop, 0);

    // suspend with banks open is still accepted
    drive(1'b1, 2'd0, 1'b0, 1'b0);
    idle(1);
    @(negedge clk);
    check("R2 suspend cke low", cke, 0);
    // request while suspended is busy
    drive(1'b1, 2'd1, 1'b0, 1'b1);
    @(negedge clk);
    check("R8 busy in suspend", busy, 1);
    drive(1'b0, 2'd0, 1'b1, 1'b1);
    drive(1'b0, 2'd0, 1'b0, 1'b1);
    @(negedge clk);
    check("R3 cke back high", cke, 1);
    check("R3 ready still low", ready, 0);
    check("R6 nop on rise", force_nop, 1);
    idle(1);
    @(negedge clk);
    check("R3 ready returned", ready, 1);

    // power-down with a bank open is held off
    drive(1'b1, 2'd1, 1'b0, 1'b0);
    @(negedge clk);
    check("R5 held", held, 1);
    idle(1);
    @(negedge clk);
    check("R5 no state change", state_dbg, 0);
    drive(1'b1, 2'd1, 1'b0, 1'b1);
    idle(3);
    drive(1'b0, 2'd0, 1'b1, 1'b1);
    idle(2);
    // self refresh, with a request and wake together
    drive(1'b1, 2'd2, 1'b0, 1'b1);
    idle(4);
    drive(1'b1, 2'd3, 1'b1, 1'b1);
    idle(3);
    // wake in normal is ignored
    drive(1'b0, 2'd0, 1'b1, 1'b1);
    idle(1);
    @(negedge clk);
    check("R8 wake ignored", state_dbg, 0);

    // deep power-down, with busy requests inside the window
    drive(1'b1, 2'd3, 1'b0, 1'b1);
    idle(5);
    drive(1'b0, 2'd0, 1'b1, 1'b1);
    nops = 0;
    for (int i = 0; i < WAIT + 20; i++) begin
      if (i == 30 || i == WAIT - 2) drive(1'b1, 2'd0, 1'b1, 1'b1);
      else drive(1'b0, 2'd0, 1'b0, 1'b1);
      @(negedge clk);
      if (cke && force_nop) nops++;
    end
    check("R7 dpd nop cycles", nops, WAIT);
    check("R7 ready after dpd", ready, 1);
    idle(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=done", cycles);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule